// File: doc/BRIEF.md
# Monochrome Raster-Op Blit Datapath

This block is the 16-bit pixel path of a one-bit-per-pixel frame buffer. Each data word holds sixteen horizontally adjacent pixels of one bit plane, most significant bit leftmost. The block sits between a host port and a single-port video memory model, which lives inside the block. The host either writes configuration registers or makes memory accesses. A memory access takes one of three routes, picked by the mode field.

In normal mode, words pass straight through to memory and back. In vector mode, a host write is a read-modify-write: the source word comes from the host data and the destination word comes from memory. In blit mode, a host write names a source word address and a destination word address. The block reads the source, funnel-shifts it against the source word held from the previous access, combines the result with the destination word through a 4-bit raster operation, and writes it back under a write-protect mask. A blit-mode read is a prime read. It only reloads the held source word, so that a copy whose destination bit offset is smaller than its source bit offset can start correctly. Software computes the shift as the destination bit offset minus the source bit offset, modulo 16. Software also walks rows in descending address order when the destination row lies below the source row.

Register map (host_reg = 1, write only, register index on host_addr[2:0]):
- Index 0, mode: bits 7:5 hold the mode code and bits 4:0 hold the shift.
- Index 1, control: bit 0 enables the raster operation.
- Index 2, source select: bits 7:6.
- Index 3, raster-op code: bits 3:0.
- Index 4, write mask: all 16 bits.

A host access with host_reg = 1 and host_we = 0 does nothing.

Top module: `mono_blit_path`

## Requirements
- R1: Reset values: mode 111 (normal), shift 0, raster-op enable 0, source select 11, raster-op code 3, write mask 0, held source word 0. host_busy and host_rvalid are low after reset.
- R2: In normal mode, a write stores host_wdata unchanged at host_addr and keeps host_busy high for 1 cycle. A read keeps host_busy high for 2 cycles and pulses host_rvalid for one cycle, with the stored word on host_rdata, 2 clocks after the accepting edge.
- R3: Normal mode ignores the shift, the raster-op code and enable, and the mask, and leaves the held source word unchanged.
- R4: In blit mode (mode 100), a write with host_addr = source address and host_wdata[AW-1:0] = destination address keeps host_busy high for 3 cycles. It then updates the destination word.
- R5: The shifted source is the low 16 bits of {held word, current source word} shifted right by the shift field modulo 16 (bit 4 is ignored). A shift of 0 gives the current source word.
- R6: Every blit-mode source read, whether a write or a prime read, replaces the held word with the current source word after source selection. A prime read writes nothing to memory and returns the raw memory word after the same 2-cycle latency as R2.
- R7: With the raster-op unit enabled, code c gives, for source S and destination D: 0 zeros, 1 S&D, 2 S&~D, 3 S, 4 ~S&D, 5 D, 6 S^D, 7 S|D, 8 ~(S|D), 9 ~(S^D), A ~D, B S|~D, C ~S, D ~S|D, E ~(S&D), F ones.
- R8: With the raster-op enable bit clear, the destination receives the shifted source, whatever the code.
- R9: A write-mask bit of 1 keeps the matching destination bit at its old value. A mask of 0 lets every bit change.
- R10: Source select 00 gives all ones, 01 gives host-visible bit 0 replicated over all 16 bits, and 11 or 10 gives the full word.
- R11: In vector mode (mode 010), a write takes its source from source-selected host_wdata, with no shift. It applies the raster operation and mask to the word at host_addr, and keeps host_busy high for 2 cycles. A vector-mode read behaves as a normal read.
- R12: Mode codes other than 010 and 100 behave exactly as normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, accepted when host_busy is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_reg | input | 1 | 1 = configuration register, 0 = memory |
| host_addr | input | AW | Word address, or register index in bits 2:0 |
| host_wdata | input | DW | Write data; in a blit write, bits AW-1:0 carry the destination address |
| host_rdata | output | DW | Read data, valid while host_rvalid is high |
| host_rvalid | output | 1 | One-cycle read-data strobe |
| host_busy | output | 1 | An accepted memory access is still in progress |

## Verification
Counting from the clock edge that accepts a request: a normal write holds host_busy for 1 cycle, a vector write for 2 and a blit write for 3. A read holds host_busy for 2 cycles and raises host_rvalid right after the second edge. Register writes take effect at the accepting edge and never raise host_busy. The bench records the accepting edge of every request. From it, the bench predicts the busy window and the edge that carries read data, and compares host_busy and host_rvalid with that prediction at every falling edge. Memory contents are checked only through later normal-mode reads, once host_busy has dropped. Those reads are handled by the same per-cycle comparison.

// File: rtl/mono_blit_pkg.sv
package mono_blit_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_MODE = 3'd0;
  localparam logic [REG_AW-1:0] RA_CTRL = 3'd1;
  localparam logic [REG_AW-1:0] RA_SRC  = 3'd2;
  localparam logic [REG_AW-1:0] RA_ROP  = 3'd3;
  localparam logic [REG_AW-1:0] RA_MASK = 3'd4;

  localparam logic [2:0] MODE_VECTOR = 3'b010;
  localparam logic [2:0] MODE_BLIT   = 3'b100;
  localparam logic [2:0] MODE_NORMAL = 3'b111;

  typedef enum logic [1:0] {
    SRCSEL_ONES  = 2'b00,
    SRCSEL_REP   = 2'b01,
    SRCSEL_RSV   = 2'b10,
    SRCSEL_PLANE = 2'b11
  } srcsel_t;

  typedef enum logic [1:0] {
    OP_NORM = 2'd0,
    OP_VEC  = 2'd1,
    OP_BLIT = 2'd2
  } op_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SRC_RD = 3'd1,
    ST_DST_RD = 3'd2,
    ST_MOD_WR = 3'd3,
    ST_DIR_WR = 3'd4,
    ST_RET    = 3'd5
  } bstate_t;

  function automatic op_t decode_mode(input logic [2:0] m);
    if (m == MODE_BLIT)        return OP_BLIT;
    else if (m == MODE_VECTOR) return OP_VEC;
    else                       return OP_NORM;
  endfunction

endpackage

// File: rtl/blit_cfg_regs.sv
module blit_cfg_regs
  import mono_blit_pkg::*;
#(
  parameter int DW  = 16,
  parameter int SHW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [2:0]        mode,
  output logic [SHW-1:0]    shamt,
  output logic              rop_en,
  output srcsel_t           src_sel,
  output logic [3:0]        rop_code,
  output logic [DW-1:0]     wmask
);

  logic unused_cfg;
  assign unused_cfg = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_NORMAL;
      shamt    <= '0;
      rop_en   <= 1'b0;
      src_sel  <= SRCSEL_PLANE;
      rop_code <= 4'h3;
      wmask    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_MODE: begin
          mode  <= wr_data[7:5];
          shamt <= wr_data[SHW-1:0];
        end
        RA_CTRL: rop_en   <= wr_data[0];
        RA_SRC:  src_sel  <= srcsel_t'(wr_data[7:6]);
        RA_ROP:  rop_code <= wr_data[3:0];
        RA_MASK: wmask    <= wr_data;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/blit_src_funnel.sv
module blit_src_funnel
  import mono_blit_pkg::*;
#(
  parameter int DW  = 16,
  parameter int SHW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld,
  input  srcsel_t        src_sel,
  input  logic [SHW-1:0] shamt,
  input  logic [DW-1:0]  raw,
  output logic [DW-1:0]  sel_word,
  output logic [DW-1:0]  shifted,
  output logic [DW-1:0]  latch_q
);

  localparam int WW = 2 * DW;

  logic [WW-1:0] win;
  logic          unused_win;

  always_comb begin
    case (src_sel)
      SRCSEL_ONES: sel_word = '1;
      SRCSEL_REP:  sel_word = {DW{raw[0]}};
      default:     sel_word = raw;
    endcase
  end

  assign win        = {latch_q, sel_word} >> shamt;
  assign shifted    = win[DW-1:0];
  assign unused_win = ^win[WW-1:DW];

  always_ff @(posedge clk) begin
    if (rst)     latch_q <= '0;
    else if (ld) latch_q <= sel_word;
  end

  always_comb begin
    if (shamt == '0) begin
      AST_ZERO_SHIFT_PASS: assert (shifted == sel_word); // R5
    end
  end

endmodule

// File: rtl/blit_rop_unit.sv
module blit_rop_unit #(
  parameter int DW = 16
) (
  input  logic          en,
  input  logic [3:0]    code,
  input  logic [DW-1:0] s,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] r
);

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic [1:0] idx;
    assign idx  = {~s[i], ~d[i]};
    assign r[i] = en ? code[idx] : s[i];
  end

  always_comb begin
    if (en && code == 4'h0) begin
      AST_ROP_CLEAR: assert (r == '0); // R7
    end
    if (en && code == 4'hF) begin
      AST_ROP_SET: assert (r == '1); // R7
    end
  end

endmodule

// File: rtl/blit_sp_ram.sv
module blit_sp_ram #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd <= mem[addr];
  end

endmodule

// File: rtl/mono_blit_path.sv
module mono_blit_path
  import mono_blit_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_we,
  input  logic          host_reg,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  output logic          host_busy
);

  localparam int SHW = $clog2(DW);

  bstate_t        state;
  op_t            op_q, op_n;
  logic           we_q;
  logic [AW-1:0]  addr_q, dst_q;
  logic [DW-1:0]  wdata_q, shft_q;

  logic [2:0]     mode;
  logic [SHW-1:0] shamt;
  logic           rop_en;
  srcsel_t        src_sel;
  logic [3:0]     rop_code;
  logic [DW-1:0]  wmask;

  logic           accept, cfg_wr;
  logic           ram_we;
  logic [AW-1:0]  ram_addr;
  logic [DW-1:0]  ram_wd, ram_q;

  logic           ld;
  logic [DW-1:0]  fun_raw, sel_word, shifted, latch_q;
  logic [DW-1:0]  rop_src, rop_out, merged;

  assign accept    = host_req && (state == ST_IDLE);
  assign cfg_wr    = accept && host_reg && host_we;
  assign op_n      = decode_mode(mode);
  assign host_busy = (state != ST_IDLE);

  blit_cfg_regs #(.DW(DW), .SHW(SHW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr),
    .wr_addr  (host_addr[REG_AW-1:0]),
    .wr_data  (host_wdata),
    .mode     (mode),
    .shamt    (shamt),
    .rop_en   (rop_en),
    .src_sel  (src_sel),
    .rop_code (rop_code),
    .wmask    (wmask)
  );

  assign ld      = (op_q == OP_BLIT) && ((state == ST_DST_RD) || (state == ST_RET));
  assign fun_raw = (op_q == OP_BLIT) ? ram_q : wdata_q;

  blit_src_funnel #(.DW(DW), .SHW(SHW)) u_funnel (
    .clk      (clk),
    .rst      (rst),
    .ld       (ld),
    .src_sel  (src_sel),
    .shamt    (shamt),
    .raw      (fun_raw),
    .sel_word (sel_word),
    .shifted  (shifted),
    .latch_q  (latch_q)
  );

  assign rop_src = (op_q == OP_BLIT) ? shft_q : sel_word;

  blit_rop_unit #(.DW(DW)) u_rop (
    .en   (rop_en),
    .code (rop_code),
    .s    (rop_src),
    .d    (ram_q),
    .r    (rop_out)
  );

  assign merged   = (ram_q & wmask) | (rop_out & ~wmask);
  assign ram_we   = (state == ST_MOD_WR) || (state == ST_DIR_WR);
  assign ram_wd   = (state == ST_DIR_WR) ? wdata_q : merged;
  assign ram_addr = ((state == ST_IDLE) || (state == ST_SRC_RD)) ? addr_q : dst_q;

  blit_sp_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .addr (ram_addr),
    .wd   (ram_wd),
    .rd   (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op_q        <= OP_NORM;
      we_q        <= 1'b0;
      addr_q      <= '0;
      dst_q       <= '0;
      wdata_q     <= '0;
      shft_q      <= '0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept && !host_reg) begin
            op_q    <= op_n;
            we_q    <= host_we;
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            dst_q   <= (host_we && op_n == OP_BLIT) ? host_wdata[AW-1:0] : host_addr;
            if (!host_we || op_n == OP_BLIT) state <= ST_SRC_RD;
            else if (op_n == OP_VEC)         state <= ST_DST_RD;
            else                             state <= ST_DIR_WR;
          end
        end
        ST_SRC_RD: state <= we_q ? ST_DST_RD : ST_RET;
        ST_DST_RD: begin
          if (op_q == OP_BLIT) shft_q <= shifted;
          state <= ST_MOD_WR;
        end
        ST_MOD_WR: state <= ST_IDLE;
        ST_DIR_WR: state <= ST_IDLE;
        ST_RET: begin
          host_rdata  <= ram_q;
          host_rvalid <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid); // R2

  AST_BLIT_WB_AFTER_READS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MOD_WR && op_q == OP_BLIT) |-> ($past(state, 2) == ST_SRC_RD)); // R4

  AST_MASK_PROTECTS: assert property (@(posedge clk) disable iff (rst)
    (ram_we && state == ST_MOD_WR) |-> ((ram_wd & wmask) == (ram_q & wmask))); // R9

  AST_NORMAL_KEEPS_LATCH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DIR_WR || (state == ST_RET && op_q != OP_BLIT)) |=> $stable(latch_q)); // R3

  AST_PREREAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RET) |-> !ram_we); // R6

endmodule

// File: tb/test_mono_blit_path.sv
module test_mono_blit_path;

  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_req = 1'b0;
  logic          host_we = 1'b0;
  logic          host_reg = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          host_rvalid;
  logic          host_busy;

  always #10 clk = ~clk;

  mono_blit_path #(.DW(DW), .AW(AW)) i_mono_blit_path (
    .clk         (clk),
    .rst         (rst),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_reg    (host_reg),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .host_busy   (host_busy)
  );

  // reference model state
  logic [15:0] mm [256];
  logic [2:0]  m_mode  = 3'b111;
  logic [3:0]  m_sh    = 4'd0;
  logic        m_ropen = 1'b0;
  logic [1:0]  m_src   = 2'b11;
  logic [3:0]  m_rop   = 4'h3;
  logic [15:0] m_mask  = 16'h0000;
  logic [15:0] m_latch = 16'h0000;

  logic [15:0] exp_rd [int];
  string       exp_tag [int];
  int cyc = 0, bstart = 0, bend = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc++;

  function automatic logic [15:0] f_sel(input logic [1:0] sel, input logic [15:0] w);
    if (sel == 2'b00)      return 16'hFFFF;
    else if (sel == 2'b01) return {16{w[0]}};
    else                   return w;
  endfunction

  function automatic logic [15:0] f_rop(input logic [3:0] c, input logic [15:0] s, input logic [15:0] d);
    case (c)
      4'h0: return 16'h0000;
      4'h1: return s & d;
      4'h2: return s & ~d;
      4'h3: return s;
      4'h4: return ~s & d;
      4'h5: return d;
      4'h6: return s ^ d;
      4'h7: return s | d;
      4'h8: return ~(s | d);
      4'h9: return ~(s ^ d);
      4'hA: return ~d;
      4'hB: return s | ~d;
      4'hC: return ~s;
      4'hD: return ~s | d;
      4'hE: return ~(s & d);
      default: return 16'hFFFF;
    endcase
  endfunction

  // per-cycle comparison against the model's timing expectations
  always @(negedge clk) begin
    logic eb;
    if (!rst && !done) begin
      eb = (cyc >= bstart) && (cyc < bend);
      n_chk++;
      if (host_busy !== eb) begin
        n_bad++;
        $display("FAIL R4 busy at cycle %0d actual=%b expected=%b", cyc, host_busy, eb);
      end
      n_chk++;
      if (exp_rd.exists(cyc)) begin
        if (host_rvalid !== 1'b1 || host_rdata !== exp_rd[cyc]) begin
          n_bad++;
          $display("FAIL %s cycle %0d actual=%b/%h expected=1/%h",
                   exp_tag[cyc], cyc, host_rvalid, host_rdata, exp_rd[cyc]);
        end
      end else if (host_rvalid !== 1'b0) begin
        n_bad++;
        $display("FAIL R2 stray rvalid at cycle %0d actual=%b expected=0", cyc, host_rvalid);
      end
    end
  end

  task automatic issue(input bit rg, input bit we, input logic [7:0] a, input logic [15:0] d,
                       input int n, input bit rd, input logic [15:0] rx, input string tag);
    int acc;
    @(posedge clk); #3;
    acc = cyc + 1;
    host_req = 1'b1; host_reg = rg; host_we = we; host_addr = a; host_wdata = d;
    bstart = acc; bend = acc + n;
    if (rd) begin
      exp_rd[acc + 2]  = rx;
      exp_tag[acc + 2] = tag;
    end
    @(posedge clk); #3;
    host_req = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic reg_wr(input logic [2:0] ra, input logic [15:0] v);
    case (ra)
      3'd0: begin m_mode = v[7:5]; m_sh = v[3:0]; end
      3'd1: m_ropen = v[0];
      3'd2: m_src   = v[7:6];
      3'd3: m_rop   = v[3:0];
      3'd4: m_mask  = v;
      default: ;
    endcase
    issue(1'b1, 1'b1, {5'd0, ra}, v, 0, 1'b0, 16'h0, "");
  endtask

  task automatic set_mode(input logic [2:0] m, input logic [4:0] sh);
    reg_wr(3'd0, {8'h00, m, sh});
  endtask

  task automatic mem_wr(input logic [7:0] a, input logic [15:0] d);
    logic [15:0] s, f, old, r;
    logic [31:0] pr;
    logic [7:0]  da;
    int n;
    if (m_mode == 3'b100) begin
      da = d[7:0]; s = f_sel(m_src, mm[a]);
      pr = {m_latch, s} >> m_sh; f = pr[15:0];
      m_latch = s; n = 3;
    end else if (m_mode == 3'b010) begin
      da = a; f = f_sel(m_src, d); n = 2;
    end else begin
      da = a; f = d; n = 1;
    end
    if (n == 1) mm[da] = d;
    else begin
      old = mm[da];
      r = m_ropen ? f_rop(m_rop, f, old) : f;
      mm[da] = (old & m_mask) | (r & ~m_mask);
    end
    issue(1'b0, 1'b1, a, d, n, 1'b0, 16'h0, "");
  endtask

  task automatic mem_rd(input logic [7:0] a, input string tag);
    logic [15:0] x;
    x = mm[a];
    if (m_mode == 3'b100) m_latch = f_sel(m_src, x);
    issue(1'b0, 1'b0, a, 16'h0, 2, 1'b1, x, tag);
  endtask

  task automatic peek(input logic [7:0] a, input string tag);
    logic [2:0] sm;
    logic [3:0] ss;
    sm = m_mode; ss = m_sh;
    if (sm != 3'b111) set_mode(3'b111, {1'b0, ss});
    mem_rd(a, tag);
    if (sm != 3'b111) set_mode(sm, {1'b0, ss});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int shs [6] = '{0, 1, 4, 7, 11, 15};
    logic [15:0] masks [4] = '{16'hFF00, 16'h0F0F, 16'hFFFF, 16'h8001};
    logic [2:0] odd_modes [5] = '{3'b000, 3'b001, 3'b011, 3'b101, 3'b110};

    repeat (4) @(posedge clk);
    #3 rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (host_busy !== 1'b0 || host_rvalid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 outputs after reset actual=%b%b expected=00", host_busy, host_rvalid);
    end

    // R2: direct fill and read-back with the reset (normal) mode
    for (int i = 0; i < 256; i++) mem_wr(8'(i), 16'(i * 965) ^ 16'hA55A);
    mem_rd(8'd0, "R2 normal read");
    mem_rd(8'd77, "R2 normal read");
    mem_rd(8'd255, "R2 normal read");

    // R1: defaults (code 3, mask 0, plane source) seen through a blit copy
    set_mode(3'b100, 5'd0);
    reg_wr(3'd1, 16'h0001);
    mem_rd(8'd0, "R6 prime read data");
    mem_wr(8'd1, 16'd100);
    peek(8'd100, "R1 default rop/mask/source blit copy, R4 blit result");

    // R5 / R6: shift sweep, each preceded by a prime read
    for (int k = 0; k < 6; k++) begin
      set_mode(3'b100, 5'(shs[k]));
      mem_rd(8'(2 + 2 * k), "R6 prime read data");
      mem_wr(8'(3 + 2 * k), 16'(101 + k));
      peek(8'(101 + k), "R5 funnel shift result");
      peek(8'(2 + 2 * k), "R6 prime read leaves memory unchanged");
    end
    reg_wr(3'd0, {8'h00, 3'b100, 5'b10011});
    mem_wr(8'd15, 16'd107);
    peek(8'd107, "R5 shift bit 4 ignored");

    // R7: all raster-op codes
    set_mode(3'b100, 5'd3);
    for (int c = 0; c < 16; c++) begin
      reg_wr(3'd3, 16'(c));
      mem_wr(8'(20 + c), 16'(140 + c));
      peek(8'(140 + c), "R7 raster-op code");
    end

    // R8: unit disabled
    reg_wr(3'd1, 16'h0000);
    reg_wr(3'd3, 16'h0006);
    mem_wr(8'd40, 16'd160);
    peek(8'd160, "R8 rop disabled gives source");

    // R9: write-protect masks
    reg_wr(3'd1, 16'h0001);
    for (int j = 0; j < 4; j++) begin
      reg_wr(3'd4, masks[j]);
      mem_wr(8'(41 + j), 16'(170 + j));
      peek(8'(170 + j), "R9 mask protects bits");
    end
    reg_wr(3'd4, 16'h0000);

    // R10: source selection
    set_mode(3'b100, 5'd0);
    reg_wr(3'd1, 16'h0000);
    for (int j = 0; j < 4; j++) begin
      reg_wr(3'd2, 16'(j << 6));
      mem_wr(8'(70 + j), 16'(180 + j));
      peek(8'(180 + j), "R10 source select");
    end
    reg_wr(3'd2, 16'h0040);
    mem_wr(8'd74, 16'd185);
    peek(8'd185, "R10 replicate zero bit");
    reg_wr(3'd2, 16'h00C0);

    // R11: vector mode
    set_mode(3'b010, 5'd5);
    reg_wr(3'd1, 16'h0001);
    reg_wr(3'd3, 16'h0006);
    reg_wr(3'd4, 16'h00F0);
    mem_wr(8'd200, 16'h1234);
    peek(8'd200, "R11 vector write");
    reg_wr(3'd2, 16'h0000);
    mem_wr(8'd201, 16'h0000);
    peek(8'd201, "R11 vector write with ones source");
    mem_rd(8'd202, "R11 vector read direct");
    reg_wr(3'd2, 16'h00C0);
    reg_wr(3'd4, 16'h0000);

    // R3: normal mode ignores settings and keeps the held word
    set_mode(3'b100, 5'd2);
    mem_rd(8'd210, "R6 prime read data");
    set_mode(3'b111, 5'd9);
    reg_wr(3'd4, 16'hFFFF);
    reg_wr(3'd3, 16'h0000);
    mem_wr(8'd211, 16'hBEEF);
    mem_rd(8'd211, "R3 normal write ignores rop and mask");
    mem_rd(8'd212, "R3 normal read");
    set_mode(3'b100, 5'd9);
    reg_wr(3'd4, 16'h0000);
    reg_wr(3'd3, 16'h0003);
    mem_wr(8'd213, 16'd214);
    peek(8'd214, "R3 held word kept across normal accesses");

    // R12: other mode codes act as normal
    for (int j = 0; j < 5; j++) begin
      set_mode(odd_modes[j], 5'd6);
      reg_wr(3'd4, 16'hFFFF);
      mem_wr(8'(220 + j), 16'hC0DE ^ 16'(j));
      mem_rd(8'(220 + j), "R12 unlisted mode acts as normal");
    end
    reg_wr(3'd4, 16'h0000);
    set_mode(3'b100, 5'd1);
    mem_wr(8'd225, 16'd226);
    peek(8'd226, "R12 held word untouched by unlisted modes");

    repeat (4) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule